// File: doc/BRIEF.md
# Two-Wire Write-Only Slave Receiver

This block is the receive side of a two-wire (SMBus style) slave that only accepts writes. It oversamples the serial clock and data lines with a fast system clock, finds START and STOP conditions, and shifts in bytes most significant bit first on each rising clock edge. It acknowledges a byte by requesting a low on the shared data line through an open-drain enable. Three transfer forms are handled: a quick command to a broadcast sync address, a one-byte command write, and a command plus two data bytes.

Results go downstream as single-cycle strobes that carry no back-pressure. The bus cannot be held, so every strobe is valid-only and the consumer must take it in the cycle it appears. A command byte is released when its acknowledge clock rises. The two data bytes are released together, only when the high byte's acknowledge clock rises. A transfer cut short by an early START or STOP therefore never delivers a partial word. Every STOP seen on the bus gives a strobe of its own, which downstream logic can use as its commit point.

The system clock must run at least 16 times faster than the serial clock.

Top module: `smb_wr_slave`

## Requirements
- R1: After reset the open-drain enable is low, and none of the command, word or quick strobes fires until a transfer takes place.
- R2: A STOP (data rising while clock is high) gives exactly one stop strobe, and a START (data falling while clock is high) begins a new address phase.
- R3: An address byte whose upper seven bits equal binary 0100 followed by the three strap inputs, and whose last bit is 0 (write), is acknowledged: the enable is high throughout the high phase of the 9th clock.
- R4: An address byte that matches neither address, or a device-address match whose last bit is 1, is not acknowledged, and later bytes up to the next START or STOP are neither acknowledged nor delivered.
- R5: In a full write word the command byte comes out on the command strobe at its acknowledge, and the low and high data bytes come out together on the word strobe at the high byte's acknowledge. All bytes are assembled most significant bit first.
- R6: A START or STOP after the command acknowledge but before the high-byte acknowledge keeps the command strobe and drops both data bytes, so no word strobe fires.
- R7: A START or STOP that arrives before the command byte is acknowledged drops that command byte, so no command strobe fires.
- R8: Address 1111110 is acknowledged whatever the straps are. Its eighth bit is given on the quick flag with the quick strobe. No byte after it is acknowledged.
- R9: Bytes after the high data byte of a write word are not acknowledged and are not delivered.
- R10: The open-drain enable stays low during the high phase of every address and data bit, and it changes only while the synchronized clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin |
| addr_strap | input | 3 | Low three bits of the device address |
| sda_pull_low | output | 1 | Open-drain enable; high pulls the data line low |
| cmd_valid | output | 1 | One-cycle strobe: command byte accepted |
| cmd_data | output | 8 | Accepted command byte |
| word_valid | output | 1 | One-cycle strobe: both data bytes accepted |
| word_lo | output | 8 | Low data byte |
| word_hi | output | 8 | High data byte |
| quick_valid | output | 1 | One-cycle strobe: sync quick command accepted |
| quick_flag | output | 1 | Eighth bit of the sync address byte |
| stop_pulse | output | 1 | One-cycle strobe on each STOP |

## Verification
Each line passes through two synchronizer flops and one history flop, and the edge pulses are then registered. A byte strobe therefore appears about four system cycles after the rising edge of its acknowledge clock. The acknowledge enable rises about four cycles after the falling edge that ends the 8th bit. The bench drives a bus quarter-period of eight system cycles and changes inputs on falling system-clock edges. It samples the acknowledge in the middle of the 9th high phase, where the enable has long settled. Strobes are counted and captured by a monitor and compared only after the STOP plus a few extra quarter-periods, which is well past every four-cycle latency.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int STRAP_W = 3;
  localparam logic [ADDR_W-STRAP_W-1:0] DEV_PREFIX = 4'b0100;
  localparam logic [ADDR_W-1:0] SYNC_ADDR = 7'b1111110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_LO,
    ST_HI,
    ST_SKIP
  } smb_state_e;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_CMD,
    EV_WORD,
    EV_QUICK
  } smb_event_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] cur,
  output logic [LINES-1:0] prev
);
  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [DEPTH-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[DEPTH-2:0], raw[g]};
    end
    assign cur[g]  = pipe[STAGES-1];
    assign prev[g] = pipe[STAGES];
  end
endmodule

// File: rtl/smb_bitrx.sv
module smb_bitrx
  import smb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              scl_q,
  input  logic              sda_s,
  input  logic              sda_q,
  output logic              start_p,
  output logic              stop_p,
  output logic              byte_p,
  output logic              ack_p,
  output logic              fall_p,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0] cnt;
  logic rise_c, fall_c, start_c, stop_c;

  assign rise_c  = scl_s & ~scl_q;
  assign fall_c  = ~scl_s & scl_q;
  assign start_c = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c  = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rx_byte <= '0;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
      byte_p  <= 1'b0;
      ack_p   <= 1'b0;
      fall_p  <= 1'b0;
    end else begin
      start_p <= start_c;
      stop_p  <= stop_c;
      fall_p  <= fall_c;
      byte_p  <= 1'b0;
      ack_p   <= 1'b0;
      if (start_c || stop_c) begin
        cnt <= '0;
      end else if (rise_c) begin
        if (cnt == CNT_W'(BYTE_W)) begin
          cnt   <= '0;
          ack_p <= 1'b1;
        end else begin
          rx_byte <= {rx_byte[BYTE_W-2:0], sda_s};
          cnt     <= cnt + 1'b1;
          if (cnt == CNT_W'(BYTE_W - 1)) byte_p <= 1'b1;
        end
      end
    end
  end

  // R2: bit counter never leaves the 0..8 window
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BYTE_W));

  // R2: a byte-complete pulse and an acknowledge-clock pulse never coincide
  a_r2_byte_ack_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_p && ack_p));
endmodule

// File: rtl/smb_seq.sv
module smb_seq
  import smb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              byte_p,
  input  logic              ack_p,
  input  logic              fall_p,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              sda_pull_low,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              word_valid,
  output logic [BYTE_W-1:0] word_lo,
  output logic [BYTE_W-1:0] word_hi,
  output logic              quick_valid,
  output logic              quick_flag,
  output logic              stop_pulse
);
  smb_state_e state, pend_next;
  smb_event_e pend_ev;
  logic       want_ack;
  logic       cmd_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      pend_next    <= ST_IDLE;
      pend_ev      <= EV_NONE;
      want_ack     <= 1'b0;
      sda_pull_low <= 1'b0;
      cmd_valid    <= 1'b0;
      word_valid   <= 1'b0;
      quick_valid  <= 1'b0;
      stop_pulse   <= 1'b0;
      cmd_data     <= '0;
      word_lo      <= '0;
      word_hi      <= '0;
      quick_flag   <= 1'b0;
    end else begin
      cmd_valid   <= 1'b0;
      word_valid  <= 1'b0;
      quick_valid <= 1'b0;
      stop_pulse  <= stop_p;
      if (start_p || stop_p) begin
        state        <= start_p ? ST_ADDR : ST_IDLE;
        pend_next    <= start_p ? ST_ADDR : ST_IDLE;
        pend_ev      <= EV_NONE;
        want_ack     <= 1'b0;
        sda_pull_low <= 1'b0;
      end else begin
        if (byte_p) begin
          pend_ev   <= EV_NONE;
          want_ack  <= 1'b0;
          pend_next <= state;
          case (state)
            ST_ADDR: begin
              if (rx_byte[BYTE_W-1:1] == dev_addr && !rx_byte[0]) begin
                want_ack  <= 1'b1;
                pend_next <= ST_CMD;
              end else if (rx_byte[BYTE_W-1:1] == SYNC_ADDR) begin
                want_ack   <= 1'b1;
                pend_next  <= ST_SKIP;
                pend_ev    <= EV_QUICK;
                quick_flag <= rx_byte[0];
              end else begin
                pend_next <= ST_SKIP;
              end
            end
            ST_CMD: begin
              want_ack  <= 1'b1;
              pend_next <= ST_LO;
              pend_ev   <= EV_CMD;
              cmd_data  <= rx_byte;
            end
            ST_LO: begin
              want_ack  <= 1'b1;
              pend_next <= ST_HI;
              word_lo   <= rx_byte;
            end
            ST_HI: begin
              want_ack  <= 1'b1;
              pend_next <= ST_SKIP;
              pend_ev   <= EV_WORD;
              word_hi   <= rx_byte;
            end
            default: ;
          endcase
        end
        if (ack_p) begin
          state       <= pend_next;
          pend_ev     <= EV_NONE;
          cmd_valid   <= (pend_ev == EV_CMD);
          word_valid  <= (pend_ev == EV_WORD);
          quick_valid <= (pend_ev == EV_QUICK);
        end
        if (fall_p) begin
          if (sda_pull_low) begin
            sda_pull_low <= 1'b0;
          end else if (want_ack) begin
            sda_pull_low <= 1'b1;
            want_ack     <= 1'b0;
          end
        end
      end
    end
  end

  // checker state: a command strobe has been given in this transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cmd_seen <= 1'b0;
    else if (start_p || stop_p)  cmd_seen <= 1'b0;
    else if (cmd_valid)          cmd_seen <= 1'b1;
  end

  // R10: the acknowledge enable only turns on while the clock is low
  a_r10_ack_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> !scl_s);

  // R5: at most one delivery strobe per cycle
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, word_valid, quick_valid}));

  // R6: a word is only delivered after its command in the same transfer
  a_r6_word_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> cmd_seen);

  // R2: a STOP leaves the block idle and releases the line
  a_r2_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> (state == ST_IDLE && !sda_pull_low));

  // R8: after a sync quick command every further byte is refused
  a_r8_quick_then_skip: assert property (@(posedge clk) disable iff (!rst_n)
    quick_valid |-> state == ST_SKIP);
endmodule

// File: rtl/smb_wr_slave.sv
module smb_wr_slave
  import smb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [STRAP_W-1:0] addr_strap,
  output logic               sda_pull_low,
  output logic               cmd_valid,
  output logic [BYTE_W-1:0]  cmd_data,
  output logic               word_valid,
  output logic [BYTE_W-1:0]  word_lo,
  output logic [BYTE_W-1:0]  word_hi,
  output logic               quick_valid,
  output logic               quick_flag,
  output logic               stop_pulse
);
  logic [1:0] line_cur, line_prev;
  logic start_p, stop_p, byte_p, ack_p, fall_p;
  logic [BYTE_W-1:0] rx_byte;
  logic [ADDR_W-1:0] dev_addr;

  assign dev_addr = {DEV_PREFIX, addr_strap};

  smb_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({scl_in, sda_in}),
    .cur  (line_cur),
    .prev (line_prev)
  );

  smb_bitrx u_bitrx (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_s  (line_cur[1]),
    .scl_q  (line_prev[1]),
    .sda_s  (line_cur[0]),
    .sda_q  (line_prev[0]),
    .start_p(start_p),
    .stop_p (stop_p),
    .byte_p (byte_p),
    .ack_p  (ack_p),
    .fall_p (fall_p),
    .rx_byte(rx_byte)
  );

  smb_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (line_cur[1]),
    .start_p     (start_p),
    .stop_p      (stop_p),
    .byte_p      (byte_p),
    .ack_p       (ack_p),
    .fall_p      (fall_p),
    .rx_byte     (rx_byte),
    .dev_addr    (dev_addr),
    .sda_pull_low(sda_pull_low),
    .cmd_valid   (cmd_valid),
    .cmd_data    (cmd_data),
    .word_valid  (word_valid),
    .word_lo     (word_lo),
    .word_hi     (word_hi),
    .quick_valid (quick_valid),
    .quick_flag  (quick_flag),
    .stop_pulse  (stop_pulse)
  );
endmodule

// File: tb/tb_smb_wr_slave.sv
module tb_smb_wr_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_pull_low, cmd_valid, word_valid, quick_valid, quick_flag, stop_pulse;
  logic [7:0] cmd_data, word_lo, word_hi;
  logic sda_bus;

  int checks = 0;
  int errors = 0;
  int n_cmd = 0, n_word = 0, n_quick = 0, n_stop = 0, n_any = 0;
  int bit_drive_err = 0;
  logic [7:0] last_cmd = 8'h00, last_lo = 8'h00, last_hi = 8'h00;
  logic last_flag = 1'b0;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull_low;

  smb_wr_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .addr_strap(strap), .sda_pull_low(sda_pull_low),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .word_valid(word_valid), .word_lo(word_lo), .word_hi(word_hi),
    .quick_valid(quick_valid), .quick_flag(quick_flag), .stop_pulse(stop_pulse)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (cmd_valid)   begin n_cmd++;   last_cmd = cmd_data; end
      if (word_valid)  begin n_word++;  last_lo = word_lo; last_hi = word_hi; end
      if (quick_valid) begin n_quick++; last_flag = quick_flag; end
      if (stop_pulse)  n_stop++;
      if (cmd_valid || word_valid || quick_valid) n_any++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    qwait(Q); sda_m = 1'b1;
    qwait(Q); scl_m = 1'b1;
    qwait(Q); sda_m = 1'b0;
    qwait(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    qwait(Q); sda_m = 1'b0;
    qwait(Q); scl_m = 1'b1;
    qwait(Q); sda_m = 1'b1;
    qwait(2 * Q);
  endtask

  task automatic bit_out(input logic v);
    qwait(Q); sda_m = v;
    qwait(Q); scl_m = 1'b1;
    qwait(Q); if (sda_pull_low) bit_drive_err++;
    qwait(Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    qwait(Q); sda_m = 1'b1;
    qwait(Q); scl_m = 1'b1;
    qwait(Q); acked = sda_pull_low;
    qwait(Q); scl_m = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 enable idle", int'(sda_pull_low), 0);
    chk("R1 no strobes", n_any, 0);
  endtask

  task automatic t_write_word();
    logic a0, a1, a2, a3;
    int c0, w0, s0;
    c0 = n_cmd; w0 = n_word; s0 = n_stop;
    bus_start();
    send_byte(8'h4A, a0); send_byte(8'hA5, a1);
    send_byte(8'h3C, a2); send_byte(8'h02, a3);
    bus_stop();
    chk("R3 address ack", int'(a0), 1);
    chk("R5 data acks", int'(a1 & a2 & a3), 1);
    chk("R5 cmd count", n_cmd - c0, 1);
    chk("R5 cmd value", int'(last_cmd), 8'hA5);
    chk("R5 word count", n_word - w0, 1);
    chk("R5 word lo", int'(last_lo), 8'h3C);
    chk("R5 word hi", int'(last_hi), 8'h02);
    chk("R2 stop strobe", n_stop - s0, 1);
  endtask

  task automatic t_wrong_addr();
    logic a0, a1;
    int any0;
    any0 = n_any;
    bus_start(); send_byte(8'h50, a0); send_byte(8'h12, a1); bus_stop();
    chk("R4 foreign address nack", int'(a0), 0);
    chk("R4 following byte nack", int'(a1), 0);
    bus_start(); send_byte(8'h4B, a0); send_byte(8'h12, a1); bus_stop();
    chk("R4 read bit nack", int'(a0), 0);
    chk("R4 read following nack", int'(a1), 0);
    chk("R4 nothing delivered", n_any - any0, 0);
  endtask

  task automatic t_send_byte();
    logic a0, a1;
    int c0, w0;
    c0 = n_cmd; w0 = n_word;
    bus_start(); send_byte(8'h4A, a0); send_byte(8'h11, a1); bus_stop();
    chk("R6 send byte cmd", n_cmd - c0, 1);
    chk("R6 send byte value", int'(last_cmd), 8'h11);
    chk("R6 send byte no word", n_word - w0, 0);
  endtask

  task automatic t_cut_after_lo();
    logic a0, a1, a2, a3;
    int c0, w0;
    c0 = n_cmd; w0 = n_word;
    bus_start(); send_byte(8'h4A, a0); send_byte(8'h22, a1); send_byte(8'h33, a2);
    bus_start(); send_byte(8'h4A, a0); send_byte(8'h44, a1); send_byte(8'h55, a2);
    send_byte(8'h66, a3); bus_stop();
    chk("R6 both cmds kept", n_cmd - c0, 2);
    chk("R6 only second word", n_word - w0, 1);
    chk("R6 second word lo", int'(last_lo), 8'h55);
    chk("R6 second word hi", int'(last_hi), 8'h66);
  endtask

  task automatic t_cut_in_cmd();
    logic a0;
    int c0, s0;
    c0 = n_cmd; s0 = n_stop;
    bus_start(); send_byte(8'h4A, a0);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b0); bit_out(1'b1);
    bus_stop();
    chk("R7 partial cmd dropped", n_cmd - c0, 0);
    chk("R2 stop after partial", n_stop - s0, 1);
  endtask

  task automatic t_sync();
    logic a0, a1;
    int q0, any0;
    q0 = n_quick;
    bus_start(); send_byte(8'hFC, a0); bus_stop();
    chk("R8 sync ack", int'(a0), 1);
    chk("R8 quick flag 0", int'(last_flag), 0);
    strap = 3'b000;
    bus_start(); send_byte(8'hFD, a0); bus_stop();
    chk("R8 sync ack other strap", int'(a0), 1);
    chk("R8 quick flag 1", int'(last_flag), 1);
    chk("R8 quick count", n_quick - q0, 2);
    any0 = n_any;
    bus_start(); send_byte(8'hFC, a0); send_byte(8'h77, a1); bus_stop();
    chk("R8 byte after sync nack", int'(a1), 0);
    chk("R8 only quick delivered", n_any - any0, 1);
    strap = 3'b101;
  endtask

  task automatic t_extra_byte();
    logic a0, a1, a2, a3, a4;
    int w0;
    w0 = n_word;
    bus_start(); send_byte(8'h4A, a0); send_byte(8'h01, a1); send_byte(8'hC3, a2);
    send_byte(8'h81, a3); send_byte(8'hEE, a4); bus_stop();
    chk("R9 extra byte nack", int'(a4), 0);
    chk("R9 one word", n_word - w0, 1);
    chk("R9 word unaffected lo", int'(last_lo), 8'hC3);
    chk("R9 word unaffected hi", int'(last_hi), 8'h81);
  endtask

  task automatic t_strap();
    logic a0, a1;
    strap = 3'b000;
    bus_start(); send_byte(8'h4A, a0); bus_stop();
    bus_start(); send_byte(8'h40, a1); bus_stop();
    chk("R3 old strap nack", int'(a0), 0);
    chk("R3 new strap ack", int'(a1), 1);
    strap = 3'b101;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    qwait(Q);
    t_reset();
    t_write_word();
    t_wrong_addr();
    t_send_byte();
    t_cut_after_lo();
    t_cut_in_cmd();
    t_sync();
    t_extra_byte();
    t_strap();
    chk("R10 no drive in data bits", bit_drive_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule